// File: doc/BRIEF.md
# Composite Sync Vertical Separator and HBLANK Inserter

The block monitors a horizontal sync input that may carry composite sync. It measures the line period as the clock count between successive leading edges of the sync pulse. Any active interval that lasts longer than half of that period is taken to be the vertical pulse embedded in the composite stream. While such a pulse is detected, the block raises a presence flag and produces a separated vertical sync. That separated sync leaves the block through a fixed delay line.

Vertical blanking can be driven either from the separated vertical sync or from the dedicated vertical sync input. Horizontal blanking normally copies the horizontal sync input. While a composite vertical pulse is in progress, however, it can instead carry substitute pulses. Each substitute pulse lasts one eighth of the measured line period and keeps the phase of the last line leading edge, so downstream logic still sees a line rhythm through the vertical interval. A control bit turns the insertion off. Separate inversion bits set the polarity of each blanking output.

Top module: `csync_sep`

## Requirements
- R1: While reset is held, csync_v, cv_present, hblank and vblank are all 0, whatever the configuration bits are.
- R2: The sync active level is high when cfg_hs_neg=0 and low when it is 1. Let P be the clock count between two successive active-going samples of hsync_in. A vertical pulse is detected only when the active interval lasts more than floor(P/2) samples. An interval of exactly floor(P/2) samples is not detected.
- R3: Suppose the active-going sample of the vertical interval is taken at edge s, and the interval lasts L samples. Then csync_v is 1 after edges s+floor(P/2)+1+DELAY_CYC through s+L+DELAY_CYC, and 0 at all other times.
- R4: cv_present becomes 1 one edge after detection starts. It remains 1 until TIMEOUT_CYC edges after detection ends, and it returns to 0 after edge s+L+1+TIMEOUT_CYC.
- R5: With cfg_no_ins=0, hblank carries the inserted pulses while detection is active. Taking the last line leading edge as edge 0, hblank is active after edges kP+2 through kP+1+P/8, and inactive otherwise.
- R6: With cfg_no_ins=1, hblank after edge m equals hsync_in as sampled at edge m-1, XOR cfg_hb_inv. This holds even during a vertical pulse.
- R7: Outside detection, hblank follows the same copy rule as R6. Inserted pulses take the raw level that hsync_in has when active, and cfg_hb_inv then inverts the result.
- R8: vblank after edge m is the selected source at edge m-1, XOR cfg_vb_inv. The source is csync_v when cfg_v_sel=1 and vsync_in when cfg_v_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Raw horizontal or composite sync |
| vsync_in | input | 1 | Raw dedicated vertical sync |
| cfg_hs_neg | input | 1 | 1: sync pulses on hsync_in are active low |
| cfg_no_ins | input | 1 | 1: disable pulse insertion on hblank |
| cfg_hb_inv | input | 1 | Invert hblank |
| cfg_v_sel | input | 1 | 1: vblank sourced from separated vertical sync |
| cfg_vb_inv | input | 1 | Invert vblank |
| csync_v | output | 1 | Separated vertical sync, delayed |
| cv_present | output | 1 | Composite vertical pulse present flag |
| hblank | output | 1 | Horizontal blanking output |
| vblank | output | 1 | Vertical blanking output |

## Verification
Each run applies several ordinary lines to the block and then one wide pulse. Every output is compared with an arithmetic prediction on every clock, across three line periods and all eight configuration patterns. The wide pulse is swept over three lengths:
- exactly half a line, which must not be detected;
- one sample more than half a line, the shortest pulse that is detected;
- more than two lines, which shows whether the inserted pulses wrap at the stored period rather than at the period containing the vertical pulse.

Each run is long enough for the presence timeout to expire, so the exact clock on which the flag clears is also checked.

// File: rtl/csync_pkg.sv
// Shared types for the composite sync separator.
// Assumes: one clock domain; all configuration bits are quasi-static.
package csync_pkg;

    // Configuration bits gathered from the top-level ports.
    typedef struct packed {
        logic hs_neg;
        logic no_ins;
        logic hb_inv;
        logic v_sel;
        logic vb_inv;
    } csync_cfg_t;

    // Source that feeds the horizontal blanking register.
    typedef enum logic {
        HB_COPY   = 1'b0,
        HB_INSERT = 1'b1
    } hb_src_e;

endpackage

// File: rtl/csync_period.sv
// Line period meter. Counts the clocks between successive leading edges of
// the polarity-normalised sync and stores the count when the interval looks
// like a normal line: at least PER_MIN clocks long, not saturated, and with
// no vertical detection inside it.
// Assumes: act_s is already registered; vp comes from the vertical detector.
module csync_period #(
    parameter int PER_W   = 12,
    parameter int PER_MIN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_s,
    input  logic             vp,
    output logic             rise,
    output logic [PER_W-1:0] per,
    output logic             per_ok
);
    localparam logic [PER_W-1:0] CNT_MAX = '1;
    localparam logic [PER_W-1:0] CNT_MIN = PER_W'(PER_MIN);

    logic             act_d;
    logic [PER_W-1:0] cnt;
    logic             vflag;
    logic             good;

    assign rise = act_s & ~act_d;
    assign good = (cnt >= CNT_MIN) && (cnt != CNT_MAX) && !vflag;

    // Edge history, interval counter, vertical marker and period store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_d  <= 1'b0;
            cnt    <= '0;
            vflag  <= 1'b0;
            per    <= '0;
            per_ok <= 1'b0;
        end else begin
            act_d <= act_s;
            if (rise) begin
                cnt <= PER_W'(1);
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + PER_W'(1);
            end
            vflag <= rise ? 1'b0 : (vflag | vp);
            if (rise && good) begin
                per    <= cnt;
                per_ok <= 1'b1;
            end
        end
    end

    // A stored period never falls below the accepted minimum (R2).
    p_period_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        per_ok |-> (per >= CNT_MIN));

endmodule

// File: rtl/csync_vdet.sv
// Vertical pulse detector. It flags an active sync interval that is longer
// than half the stored line period, delays that flag through a DELAY_CYC
// stage line to form the separated vertical sync, and holds a presence flag
// that times out TIMEOUT_CYC clocks after the last detection.
// Assumes: TIMEOUT_CYC >= 1; act_s is registered.
module csync_vdet #(
    parameter int PER_W       = 12,
    parameter int DELAY_CYC   = 96,
    parameter int TIMEOUT_CYC = 1200000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_s,
    input  logic [PER_W-1:0] per,
    input  logic             per_ok,
    output logic             vp,
    output logic             csync_v,
    output logic             present
);
    localparam int               TO_W   = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TO_W-1:0]  TO_MAX = TO_W'(TIMEOUT_CYC);
    localparam logic [PER_W-1:0] W_MAX  = '1;

    logic [PER_W-1:0] wcnt;
    logic [PER_W-1:0] half;
    logic [TO_W-1:0]  tcnt;

    assign half = per >> 1;

    // Width counter for the current active interval and detection register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            vp   <= 1'b0;
        end else begin
            if (!act_s) begin
                wcnt <= '0;
            end else if (wcnt != W_MAX) begin
                wcnt <= wcnt + PER_W'(1);
            end
            vp <= act_s && per_ok && (wcnt >= half);
        end
    end

    generate
        if (DELAY_CYC == 0) begin : g_nodelay
            assign csync_v = vp;
        end else begin : g_delay
            logic [DELAY_CYC-1:0] dline;
            // Fixed-length shift line that forms the separated vertical sync.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dline <= '0;
                end else begin
                    dline[0] <= vp;
                    for (int i = 1; i < DELAY_CYC; i++) begin
                        dline[i] <= dline[i-1];
                    end
                end
            end
            assign csync_v = dline[DELAY_CYC-1];
        end
    endgenerate

    // Presence flag with a saturating timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt    <= '0;
            present <= 1'b0;
        end else if (vp) begin
            tcnt    <= '0;
            present <= 1'b1;
        end else begin
            if (tcnt != TO_MAX) begin
                tcnt <= tcnt + TO_W'(1);
            end
            if (tcnt == TO_MAX - TO_W'(1)) begin
                present <= 1'b0;
            end
        end
    end

    // Detection ends one clock after the sync leaves its active level (R2).
    p_vp_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !act_s |=> !vp);

    // Detection raises the presence flag on the next clock (R4).
    p_present_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vp |=> present);

    // An expired timeout leaves the flag cleared (R4).
    p_timeout_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tcnt == TO_MAX) |-> !present);

endmodule

// File: rtl/csync_hins.sv
// HBLANK generator. A phase counter restarts on each line leading edge and
// wraps at the stored period. While a vertical pulse is detected and
// insertion is enabled, HBLANK carries a pulse lasting the first eighth of
// each phase cycle; otherwise HBLANK copies the registered raw sync.
// Assumes: rise, per and vp come from the period meter and the detector.
module csync_hins #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [PER_W-1:0] per,
    input  logic             vp,
    input  logic             hs_raw,
    input  logic             no_ins,
    input  logic             hs_neg,
    input  logic             hb_inv,
    output logic             hblank
);
    import csync_pkg::*;

    logic [PER_W-1:0] ph;
    logic [PER_W-1:0] ins_len;
    logic             ins;
    hb_src_e          src;
    logic             hb_bit;

    assign ins_len = per >> 3;
    assign ins     = (ph != '0) && (ph <= ins_len);
    assign src     = (vp && !no_ins) ? HB_INSERT : HB_COPY;
    assign hb_bit  = (src == HB_INSERT) ? (ins ^ hs_neg) : hs_raw;

    // Phase counter locked to the line leading edge, wrapping at the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (rise || (ph >= per)) begin
            ph <= PER_W'(1);
        end else begin
            ph <= ph + PER_W'(1);
        end
    end

    // Output register with polarity control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hblank <= 1'b0;
        end else begin
            hblank <= hb_bit ^ hb_inv;
        end
    end

    // With insertion disabled, HBLANK copies the registered raw sync (R6).
    p_copy_when_noins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        no_ins |=> (hblank == ($past(hs_raw) ^ $past(hb_inv))));

endmodule

// File: rtl/csync_sep.sv
// Composite sync separator and HBLANK inserter, top level. It registers the
// raw sync inputs, normalises the horizontal polarity, and connects the
// period meter, the vertical detector and the HBLANK generator. It also
// selects and inverts the VBLANK source.
// Assumes: sync inputs are synchronous to clk or already synchronised.
module csync_sep #(
    parameter int PER_W       = 12,
    parameter int PER_MIN     = 16,
    parameter int DELAY_CYC   = 96,
    parameter int TIMEOUT_CYC = 1200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic cfg_hs_neg,
    input  logic cfg_no_ins,
    input  logic cfg_hb_inv,
    input  logic cfg_v_sel,
    input  logic cfg_vb_inv,
    output logic csync_v,
    output logic cv_present,
    output logic hblank,
    output logic vblank
);
    import csync_pkg::*;

    csync_cfg_t       cfg;
    logic             hs_raw;
    logic             vs_raw;
    logic             act_s;
    logic             rise;
    logic             vp;
    logic             per_ok;
    logic [PER_W-1:0] per;

    assign cfg   = '{hs_neg: cfg_hs_neg, no_ins: cfg_no_ins, hb_inv: cfg_hb_inv,
                     v_sel: cfg_v_sel, vb_inv: cfg_vb_inv};
    assign act_s = hs_raw ^ cfg.hs_neg;

    // Input sampling registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_raw <= 1'b0;
            vs_raw <= 1'b0;
        end else begin
            hs_raw <= hsync_in;
            vs_raw <= vsync_in;
        end
    end

    // VBLANK source select and polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vblank <= 1'b0;
        end else begin
            vblank <= (cfg.v_sel ? csync_v : vs_raw) ^ cfg.vb_inv;
        end
    end

    csync_period #(
        .PER_W   (PER_W),
        .PER_MIN (PER_MIN)
    ) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_s  (act_s),
        .vp     (vp),
        .rise   (rise),
        .per    (per),
        .per_ok (per_ok)
    );

    csync_vdet #(
        .PER_W       (PER_W),
        .DELAY_CYC   (DELAY_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_vdet (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_s   (act_s),
        .per     (per),
        .per_ok  (per_ok),
        .vp      (vp),
        .csync_v (csync_v),
        .present (cv_present)
    );

    csync_hins #(
        .PER_W (PER_W)
    ) u_hins (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (rise),
        .per    (per),
        .vp     (vp),
        .hs_raw (hs_raw),
        .no_ins (cfg.no_ins),
        .hs_neg (cfg.hs_neg),
        .hb_inv (cfg.hb_inv),
        .hblank (hblank)
    );

    // VBLANK follows the dedicated input when the separated source is off (R8).
    p_vblank_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_v_sel |=> (vblank == ($past(vs_raw) ^ $past(cfg_vb_inv))));

endmodule

// File: tb/csync_sep_tb.sv
`timescale 1ns/1ps
module csync_sep_tb;
    localparam int PW   = 10;
    localparam int PMIN = 8;
    localparam int DL   = 6;
    localparam int TO   = 300;
    localparam int LW   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_in = 1'b0;
    logic vsync_in = 1'b0;
    logic cfg_hs_neg = 1'b0;
    logic cfg_no_ins = 1'b0;
    logic cfg_hb_inv = 1'b0;
    logic cfg_v_sel = 1'b0;
    logic cfg_vb_inv = 1'b0;
    logic csync_v, cv_present, hblank, vblank;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    int gP, gL, gN0, gK;

    always #2.5 clk = ~clk;

    csync_sep #(
        .PER_W(PW), .PER_MIN(PMIN), .DELAY_CYC(DL), .TIMEOUT_CYC(TO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .cfg_hs_neg(cfg_hs_neg), .cfg_no_ins(cfg_no_ins), .cfg_hb_inv(cfg_hb_inv),
        .cfg_v_sel(cfg_v_sel), .cfg_vb_inv(cfg_vb_inv),
        .csync_v(csync_v), .cv_present(cv_present), .hblank(hblank), .vblank(vblank)
    );

    // Active-level sync pattern: lines of width LW, then one wide pulse.
    function automatic bit act_f(int n);
        if (n < 0) return 1'b0;
        if (n >= gN0 && n < gN0 + gL) return 1'b1;
        if (n >= gN0 && n < gN0 + gK * gP) return 1'b0;
        return (n % gP) < LW;
    endfunction

    function automatic bit vin_f(int n);
        if (n < 0) return 1'b0;
        return ((n / 37) % 2) == 1;
    endfunction

    function automatic bit vp_f(int n);
        return (gL > gP / 2) && (n >= gN0 + gP / 2 + 1) && (n <= gN0 + gL);
    endfunction

    function automatic bit present_f(int m);
        return (gL > gP / 2) && (m >= gN0 + gP / 2 + 2) && (m < gN0 + gL + 1 + TO);
    endfunction

    task automatic check1(string req, string what, logic got, logic exp, int m);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s edge %0d P=%0d L=%0d: got %0b expected %0b",
                     req, what, m, gP, gL, got, exp);
        end
    endtask

    task automatic run_scn(int p, int l, int c);
        int total;
        gP = p; gL = l; gN0 = 3 * p; gK = l / p + 1;
        cfg_hs_neg = c[0];
        cfg_no_ins = c[1];
        cfg_hb_inv = c[2];
        cfg_v_sel  = c[0] ^ c[1];
        cfg_vb_inv = c[1] ^ c[2];
        rst_n = 1'b0;
        hsync_in = cfg_hs_neg;
        vsync_in = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state
        check1("R1", "csync_v", csync_v, 1'b0, -1);
        check1("R1", "cv_present", cv_present, 1'b0, -1);
        check1("R1", "hblank", hblank, 1'b0, -1);
        check1("R1", "vblank", vblank, 1'b0, -1);
        rst_n = 1'b1;
        hsync_in = act_f(0) ^ cfg_hs_neg;
        vsync_in = vin_f(0);
        total = gN0 + gL + 1 + TO + 2 * p;
        for (int n = 1; n <= total; n++) begin
            int m;
            bit hexp;
            bit vsrc;
            @(negedge clk);
            m = n - 1;
            if (m >= 2) begin
                // R2 at the threshold lengths, R3 for the long pulse
                if (gL <= gP / 2 + 1)
                    check1("R2", "csync_v", csync_v, vp_f(m - DL), m);
                else
                    check1("R3", "csync_v", csync_v, vp_f(m - DL), m);
                check1("R4", "cv_present", cv_present, present_f(m), m);
                if (vp_f(m - 1) && !cfg_no_ins) begin
                    hexp = ((((m - 2) % gP) < gP / 8) ? 1'b1 : 1'b0) ^ cfg_hs_neg ^ cfg_hb_inv;
                    check1("R5", "hblank", hblank, hexp, m);
                end else begin
                    hexp = act_f(m - 1) ^ cfg_hs_neg ^ cfg_hb_inv;
                    if (cfg_no_ins)
                        check1("R6", "hblank", hblank, hexp, m);
                    else
                        check1("R7", "hblank", hblank, hexp, m);
                end
                vsrc = cfg_v_sel ? vp_f(m - 1 - DL) : vin_f(m - 1);
                check1("R8", "vblank", vblank, vsrc ^ cfg_vb_inv, m);
            end
            hsync_in = act_f(n) ^ cfg_hs_neg;
            vsync_in = vin_f(n);
        end
    endtask

    initial begin
        for (int pi = 0; pi < 3; pi++) begin
            for (int li = 0; li < 3; li++) begin
                for (int c = 0; c < 8; c++) begin
                    int p;
                    int l;
                    p = 32 + 16 * pi;
                    l = (li == 0) ? p / 2 : ((li == 1) ? p / 2 + 1 : 2 * p + 5);
                    run_scn(p, l, c);
                end
            end
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule